// File: doc/BRIEF.md
# Masked Content-Addressable Match Engine

This block keeps a table of 64-bit entries. The table depth is a parameter. Each incoming 64-bit search word is compared, in a single cycle, against every valid entry. A global mask decides which bit positions take part in the comparison. Every accepted search ends with a one-cycle completion strobe. When some valid entry matches, the block also raises a hit flag and presents the low 32 bits of that entry on the result bus with an output-enable. On a miss the output-enable stays low and the bus reads zero. An outer wired structure can therefore combine several engines for depth expansion.

The search request is a valid/ready stream, and the result is a one-cycle pulse with no back-pressure. The block accepts a request only when `srch_valid` and `srch_ready` are both high at a clock edge. A requester holds its word until that edge. `srch_ready` falls for a programmed number of idle cycles after each accepted search. It also stays low while `match_en` is low.

Insertion is a second valid/ready stream. An insertion fills the lowest free slot, and `wr_ready` drops when the table is full. Deletion by key is a plain strobe, always accepted. It clears every valid entry that equals the key under the current mask.

Top module: `cam_match_engine`

## Requirements
- R1: A global mask bit of 0 makes that bit position take part in the comparison. A mask bit of 1 excludes it. An entry matches when all included bits are equal to the search word.
- R2: `srch_done` is high for exactly the one clock cycle after each accepted search (edge with `srch_valid` and `srch_ready` high), for a hit and for a miss alike.
- R3: In that result cycle, `srch_hit` and `res_oe` are high only if some valid entry matches. `res_data` then equals bits 31:0 of the matching entry, whatever the mask says.
- R4: In every cycle without a hit, `res_oe` and `srch_hit` are low and `res_data` is zero.
- R5: When several valid entries match, the entry in the lowest slot index supplies `res_data`.
- R6: An insertion accepted with `wr_valid` and `wr_ready` high stores `wr_entry` in the lowest-index free slot. The entry is visible to searches from the next cycle. `wr_ready` is low while every slot is valid, and an insertion offered then leaves the table unchanged.
- R7: A cycle with `del_valid` high invalidates every valid entry that matches `del_key` under the mask. Later searches for such an entry miss.
- R8: While `match_en` is low, `srch_ready` is low and no search is accepted, so `srch_done` stays low.
- R9: After an accepted search, `srch_ready` is low for exactly IDLE_CYC cycles before it can rise again.
- R10: Reset clears every valid bit and drives `srch_done`, `srch_hit` and `res_oe` low. `srch_ready` and `wr_ready` are high after reset when `match_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| match_en | input | 1 | Allows searches when high |
| gmask | input | 64 | Global mask, 1 excludes a bit |
| srch_valid | input | 1 | Search word offered |
| srch_ready | output | 1 | Search word can be taken |
| srch_key | input | 64 | Search word |
| srch_done | output | 1 | Completion strobe, one cycle |
| srch_hit | output | 1 | Search found a valid entry |
| res_data | output | 32 | Low half of matching entry |
| res_oe | output | 1 | Result bus is driven |
| wr_valid | input | 1 | Insertion offered |
| wr_ready | output | 1 | A free slot exists |
| wr_entry | input | 64 | Entry to insert |
| del_valid | input | 1 | Delete strobe |
| del_key | input | 64 | Key of entries to delete |

## Verification
A corrupted valid bit shows up on the first search for the affected entry. It appears as a miss where a hit was due, or as a hit on a deleted or never-written slot, one cycle after acceptance. A wrong priority or slot allocation shows up as the wrong low half on `res_data` in that same result cycle. A broken idle counter shows up immediately on `srch_ready`, in the cycles right after an accepted search.

// File: rtl/cam_pkg.sv
package cam_pkg;
  parameter int ENTRY_W = 64;
  parameter int DATA_W  = 32;
  typedef logic [ENTRY_W-1:0] entry_t;
  typedef logic [DATA_W-1:0]  rdata_t;
endpackage

// File: rtl/cam_compare.sv
module cam_compare
  import cam_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DEPTH-1:0][ENTRY_W-1:0] mem,
  input  logic [DEPTH-1:0]      vld,
  input  entry_t                key,
  input  entry_t                mask,
  output logic [DEPTH-1:0]      hits,
  output logic                  any,
  output logic [IW-1:0]         idx
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hits[i] = vld[i] && (((mem[i] ^ key) & ~mask) == '0);
  end

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end

  // R5
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (hits[idx] && ((hits & ((DEPTH'(1) << idx) - DEPTH'(1))) == '0)));
endmodule

// File: rtl/cam_table.sv
module cam_table
  import cam_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  input  entry_t                wr_entry,
  output logic                  wr_ready,
  input  logic                  del_valid,
  input  logic [DEPTH-1:0]      del_hits,
  output logic [DEPTH-1:0][ENTRY_W-1:0] mem,
  output logic [DEPTH-1:0]      vld
);
  logic [DEPTH-1:0] free_pick;
  logic             wr_fire;

  always_comb begin
    free_pick = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld[i]) free_pick = DEPTH'(1) << i;
    end
  end

  assign wr_ready = ~&vld;
  assign wr_fire  = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      vld <= (vld & ~(del_valid ? del_hits : '0)) | (wr_fire ? free_pick : '0);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_fire && free_pick[i]) mem[i] <= wr_entry;
    end
  end

  // R6
  insert_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !del_valid) |=> ($countones(vld) == $countones($past(vld)) + 1));

  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !del_valid) |=> (vld == $past(vld)));
endmodule

// File: rtl/cam_pace.sv
module cam_pace #(
  parameter int IDLE_CYC = 2,
  localparam int CW = $clog2(IDLE_CYC + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fire,
  output logic ready
);
  logic [CW-1:0] cnt;

  assign ready = en && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (fire)       cnt <= CW'(IDLE_CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  // R9
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (IDLE_CYC > 0)) |=> !ready);
endmodule

// File: rtl/cam_match_engine.sv
module cam_match_engine
  import cam_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int IDLE_CYC = 2,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        match_en,
  input  logic [63:0] gmask,
  input  logic        srch_valid,
  output logic        srch_ready,
  input  logic [63:0] srch_key,
  output logic        srch_done,
  output logic        srch_hit,
  output logic [31:0] res_data,
  output logic        res_oe,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [63:0] wr_entry,
  input  logic        del_valid,
  input  logic [63:0] del_key
);
  logic [DEPTH-1:0][ENTRY_W-1:0] mem;
  logic [DEPTH-1:0] vld, s_hits, d_hits;
  logic             s_any, d_any;
  logic [IW-1:0]    s_idx, d_idx;
  logic             s_fire;
  entry_t           win;

  assign s_fire = srch_valid && srch_ready;

  cam_pace #(.IDLE_CYC(IDLE_CYC)) u_pace (
    .clk(clk), .rst_n(rst_n), .en(match_en), .fire(s_fire), .ready(srch_ready));

  cam_table #(.DEPTH(DEPTH)) u_tab (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_entry(wr_entry),
    .wr_ready(wr_ready), .del_valid(del_valid), .del_hits(d_hits),
    .mem(mem), .vld(vld));

  cam_compare #(.DEPTH(DEPTH)) u_scmp (
    .clk(clk), .rst_n(rst_n), .mem(mem), .vld(vld), .key(srch_key),
    .mask(gmask), .hits(s_hits), .any(s_any), .idx(s_idx));

  cam_compare #(.DEPTH(DEPTH)) u_dcmp (
    .clk(clk), .rst_n(rst_n), .mem(mem), .vld(vld), .key(del_key),
    .mask(gmask), .hits(d_hits), .any(d_any), .idx(d_idx));

  assign win = mem[s_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srch_done <= 1'b0;
      srch_hit  <= 1'b0;
      res_oe    <= 1'b0;
      res_data  <= '0;
    end else begin
      srch_done <= s_fire;
      srch_hit  <= s_fire && s_any;
      res_oe    <= s_fire && s_any;
      res_data  <= (s_fire && s_any) ? win[DATA_W-1:0] : '0;
    end
  end

  // R2
  done_follows_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srch_done == $past(s_fire));

  // R3
  hit_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_hit || res_oe) |-> srch_done);

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !match_en |=> !srch_done);

  // R4
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_oe |-> (res_data == '0));

  // R7
  delete_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (del_valid && d_any) |=> !vld[$past(d_idx)]);
endmodule

// File: tb/cam_match_engine_test.sv
module cam_match_engine_test;
  localparam int DEPTH = 16;
  localparam int IDLE = 2;

  logic        clk = 0, rst_n = 0, match_en = 1;
  logic [63:0] gmask = '0, srch_key = '0, wr_entry = '0, del_key = '0;
  logic        srch_valid = 0, wr_valid = 0, del_valid = 0;
  logic        srch_ready, srch_done, srch_hit, res_oe, wr_ready;
  logic [31:0] res_data;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  cam_match_engine #(.DEPTH(DEPTH), .IDLE_CYC(IDLE)) uut (
    .clk(clk), .rst_n(rst_n), .match_en(match_en), .gmask(gmask),
    .srch_valid(srch_valid), .srch_ready(srch_ready), .srch_key(srch_key),
    .srch_done(srch_done), .srch_hit(srch_hit), .res_data(res_data),
    .res_oe(res_oe), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_entry(wr_entry), .del_valid(del_valid), .del_key(del_key));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic insert(input logic [63:0] e);
    wr_valid = 1; wr_entry = e;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic delete(input logic [63:0] k);
    del_valid = 1; del_key = k;
    @(negedge clk); del_valid = 0;
  endtask

  // one search; returns outputs in the result cycle
  task automatic search(input logic [63:0] k, output logic d, output logic h,
                        output logic oe, output logic [31:0] dat);
    int w = 0;
    while (!srch_ready && w < 20) begin @(negedge clk); w++; end
    srch_valid = 1; srch_key = k;
    @(negedge clk); srch_valid = 0;
    d = srch_done; h = srch_hit; oe = res_oe; dat = res_data;
  endtask

  task automatic expect_hit(input logic [63:0] k, input logic [31:0] exp, input string req);
    logic d, h, oe; logic [31:0] dat;
    search(k, d, h, oe, dat);
    check(d && h && oe && dat == exp, req, {29'd0, d, h, oe, dat}, {32'h7, exp});
  endtask

  task automatic expect_miss(input logic [63:0] k, input string req);
    logic d, h, oe; logic [31:0] dat;
    search(k, d, h, oe, dat);
    check(d && !h && !oe && dat == 0, req, {29'd0, d, h, oe, dat}, {32'h4, 32'h0});
  endtask

  task automatic t_reset();
    // R10
    check(!srch_done && !srch_hit && !res_oe, "R10 outputs", {srch_done, srch_hit, res_oe}, 0);
    check(srch_ready && wr_ready, "R10 ready", {srch_ready, wr_ready}, 2'b11);
    expect_miss(64'h0, "R10 empty table miss");
  endtask

  task automatic t_basic();
    gmask = '0;
    insert(64'h1111_2222_AAAA_0001);
    insert(64'h3333_4444_BBBB_0002);
    expect_hit(64'h1111_2222_AAAA_0001, 32'hAAAA_0001, "R3 exact hit");
    expect_hit(64'h3333_4444_BBBB_0002, 32'hBBBB_0002, "R2 second hit");
    expect_miss(64'h3333_4444_BBBB_0003, "R4 one-bit miss");
  endtask

  task automatic t_mask();
    // R1: exclude low half; low half still returned (R3)
    gmask = 64'h0000_0000_FFFF_FFFF;
    expect_hit(64'h3333_4444_0000_0000, 32'hBBBB_0002, "R1 masked low half");
    gmask = 64'hFFFF_0000_0000_0000;
    expect_hit(64'h9999_2222_AAAA_0001, 32'hAAAA_0001, "R1 masked top bits");
    gmask = 64'h0000_0000_0000_0000;
    expect_miss(64'h9999_2222_AAAA_0001, "R1 bit included mismatches");
  endtask

  task automatic t_priority();
    // both entries share high half 5555_6666; slot order decides
    insert(64'h5555_6666_0000_00A1);
    insert(64'h5555_6666_0000_00B2);
    gmask = 64'h0000_0000_FFFF_FFFF;
    expect_hit(64'h5555_6666_0000_0000, 32'h0000_00A1, "R5 lowest slot");
    gmask = '0;
  endtask

  task automatic t_delete();
    delete(64'h5555_6666_0000_00A1);
    expect_miss(64'h5555_6666_0000_00A1, "R7 deleted entry misses");
    gmask = 64'h0000_0000_FFFF_FFFF;
    expect_hit(64'h5555_6666_0000_0000, 32'h0000_00B2, "R7 other entry kept");
    delete(64'h5555_6666_0000_0000);
    expect_miss(64'h5555_6666_0000_0000, "R7 masked delete");
    gmask = '0;
    expect_hit(64'h1111_2222_AAAA_0001, 32'hAAAA_0001, "R7 unrelated kept");
  endtask

  task automatic t_enable();
    match_en = 0;
    @(negedge clk);
    check(!srch_ready, "R8 ready low", srch_ready, 0);
    srch_valid = 1; srch_key = 64'h1111_2222_AAAA_0001;
    @(negedge clk); @(negedge clk);
    check(!srch_done && !res_oe, "R8 no done", {srch_done, res_oe}, 0);
    srch_valid = 0; match_en = 1;
    @(negedge clk);
  endtask

  task automatic t_idle();
    logic d, h, oe; logic [31:0] dat;
    int lows = 0;
    search(64'h1111_2222_AAAA_0001, d, h, oe, dat);
    while (!srch_ready && lows < 10) begin lows++; @(negedge clk); end
    check(lows == IDLE, "R9 idle cycles", lows, IDLE);
  endtask

  task automatic t_full();
    int cnt = 0;
    while (wr_ready && cnt < DEPTH + 2) begin
      insert(64'hC000_0000_0000_0000 | 64'(cnt));
      cnt++;
    end
    // two slots already hold 1111.. and 3333..
    check(cnt == DEPTH - 2 && !wr_ready, "R6 full", cnt, DEPTH - 2);
    insert(64'hDEAD_BEEF_0000_0077);
    expect_miss(64'hDEAD_BEEF_0000_0077, "R6 insert while full ignored");
    delete(64'hC000_0000_0000_0003);
    check(wr_ready, "R6 ready after delete", wr_ready, 1);
    insert(64'hDEAD_BEEF_0000_0077);
    expect_hit(64'hDEAD_BEEF_0000_0077, 32'h0000_0077, "R6 refill slot");
  endtask

  task automatic t_reset_clears();
    do_reset();
    expect_miss(64'h1111_2222_AAAA_0001, "R10 reset clears valid");
  endtask

  initial begin
    do_reset();
    t_reset();
    t_basic();
    t_mask();
    t_priority();
    t_delete();
    t_enable();
    t_idle();
    t_full();
    t_reset_clears();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule